// File: doc/BRIEF.md
# DLL Sampling Phase Programmer

This block selects one of sixteen output phases of a delay-locked loop by running an ordered read-modify-write sequence on a local 32-bit configuration word. A caller presents a 4-bit phase request with a one-cycle start strobe. The block first gates the DLL clock output and moves phase control from the recovery loop to an external select. Once the delay line reports that its clock output is off, the block writes a gray-coded select value. It then re-enables the clock output and hands control back to the recovery loop.

The delay line returns one status bit that follows the clock-output enable after some latency. The block waits on this bit before and after the select write. Each wait polls a bounded number of times, with a fixed spacing derived from a cycles-per-microsecond parameter. If a wait expires, the sequence stops where it is and a sticky timeout flag is raised. A clean finish produces a one-cycle done pulse instead.

Top module: `dllph_programmer`

## Requirements
- R1: After reset the configuration word is 0 and `done_o`, `timeout_o` and `busy_o` are low.
- R2: Phase p is written to the 4-bit select field at bits 23:20 as a gray code. Phases 0 through 15 map in order to 0,1,3,2,6,7,5,4,C,D,F,E,A,B,9,8.
- R3: The first step sets DLL enable (bit 16) and external-select enable (bit 19) and clears recovery enable (bit 17) and clock-output enable (bit 18). The select field changes only while bit 18 is clear and after the status input has been sampled low.
- R4: After the select write, bit 18 is set. It rises only while bits 16 and 19 are set and bit 17 is clear. The block then waits for the status input to read 1.
- R5: The final step sets bit 17 and clears bit 19, which leaves bits 16, 17 and 18 set. `done_o` then pulses high for exactly one cycle.
- R6: In each wait, the status is sampled on the first cycle of the wait and then every CYCLES_PER_US cycles. Let k1 and k2 be the indices of the first matching sample in the low wait and the high wait. `done_o` is then first high 6+(k1+k2)*CYCLES_PER_US clock edges after the edge that accepts the start.
- R7: When MAX_POLLS samples in one wait all mismatch, the sequence aborts without `done_o`. In that case `timeout_o` goes high and stays high, and the configuration word keeps the value it had at the abort.
- R8: A start that is accepted clears `timeout_o` on the same edge.
- R9: A start or phase change while `busy_o` is high has no effect on the running sequence or its result.
- R10: Bits of the configuration word outside 23:16 stay 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| phase_i | input | 4 | Requested phase index, 0 to 15 |
| cko_status_i | input | 1 | Clock-output state reported by the delay line |
| cfg_word_o | output | 32 | DLL configuration word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Sticky wait-expiry flag |

## Verification
The ordering properties assume that the status input is synchronous to `clk`. They do not assume that the status ever follows the enable, because a stuck status must still give a clean abort. They also assume that `start_i` and `phase_i` change only away from the rising edge. The stimulus meets these conditions by deriving the status from a delayed copy of bit 18 with a latency of 0 to 255 cycles, or by holding it stuck at 0 or 1 only between sequences. It also drives every input on the falling edge and leaves at least 300 idle cycles between sequences, so the delayed copy always settles before the next start.

// File: rtl/dllph_pkg.sv
package dllph_pkg;

    localparam int CFG_W   = 32;
    localparam int B_DLL   = 16;
    localparam int B_RCV   = 17;
    localparam int B_CKO   = 18;
    localparam int B_EXT   = 19;
    localparam int SEL_LSB = 20;
    localparam int SEL_W   = 4;
    localparam logic [CFG_W-1:0] CFG_MASK = 32'h00FF_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_WAIT_LOW,
        ST_LOAD_SEL,
        ST_RAISE_CKO,
        ST_WAIT_HIGH,
        ST_HANDOVER
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_PREP,
        OP_LOAD,
        OP_RAISE,
        OP_HAND
    } cfg_op_e;

    typedef struct packed {
        seq_state_e       state;
        logic [SEL_W-1:0] phase;
        logic [CFG_W-1:0] cfg;
        logic             done;
        logic             timeout;
    } seq_regs_t;

endpackage

// File: rtl/dllph_gray_enc.sv
module dllph_gray_enc #(
    parameter int W = 4
) (
    input  logic [W-1:0] bin_i,
    output logic [W-1:0] gray_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == W - 1) begin : g_msb
            assign gray_o[i] = bin_i[i];
        end else begin : g_low
            assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
        end
    end

endmodule

// File: rtl/dllph_poll_timer.sv
module dllph_poll_timer #(
    parameter int CYCLES_PER_US = 100,
    parameter int MAX_POLLS     = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic match_i,
    output logic hit_o,
    output logic expire_o
);

    localparam int TICK_W = $clog2(CYCLES_PER_US + 1);
    localparam int POLL_W = $clog2(MAX_POLLS + 1);
    localparam logic [TICK_W-1:0] TICK_RELOAD = TICK_W'(CYCLES_PER_US - 1);
    localparam logic [POLL_W-1:0] POLL_LAST   = POLL_W'(MAX_POLLS - 1);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [POLL_W-1:0] poll;
    } timer_regs_t;

    timer_regs_t r_q, r_d;
    logic        sample_now;

    assign sample_now = active_i && (r_q.tick == '0);
    assign hit_o      = sample_now && match_i;
    assign expire_o   = sample_now && !match_i && (r_q.poll == POLL_LAST);

    always_comb begin
        r_d = r_q;
        if (!active_i) begin
            r_d.tick = '0;
            r_d.poll = '0;
        end else if (r_q.tick != '0) begin
            r_d.tick = r_q.tick - 1'b1;
        end else if (!match_i && (r_q.poll != POLL_LAST)) begin
            r_d.poll = r_q.poll + 1'b1;
            r_d.tick = TICK_RELOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.poll <= POLL_LAST); // R6
    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.tick <= TICK_RELOAD); // R6
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_o && expire_o)); // R7

endmodule

// File: rtl/dllph_cfg_update.sv
module dllph_cfg_update
    import dllph_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_i,
    input  cfg_op_e          op_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [CFG_W-1:0] cfg_o
);

    always_comb begin
        cfg_o = cfg_i;
        case (op_i)
            OP_PREP: begin
                cfg_o[B_RCV] = 1'b0;
                cfg_o[B_CKO] = 1'b0;
                cfg_o[B_EXT] = 1'b1;
                cfg_o[B_DLL] = 1'b1;
            end
            OP_LOAD: begin
                cfg_o[SEL_LSB +: SEL_W] = sel_i;
            end
            OP_RAISE: begin
                cfg_o[B_CKO] = 1'b1;
            end
            OP_HAND: begin
                cfg_o[B_RCV] = 1'b1;
                cfg_o[B_EXT] = 1'b0;
            end
            default: begin
                cfg_o = cfg_i;
            end
        endcase
    end

endmodule

// File: rtl/dllph_programmer.sv
module dllph_programmer
    import dllph_pkg::*;
#(
    parameter int CYCLES_PER_US = 100,
    parameter int MAX_POLLS     = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0]       phase_i,
    input  logic             cko_status_i,
    output logic [31:0]      cfg_word_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_o
);

    seq_regs_t        s_q, s_d;
    cfg_op_e          op;
    logic [SEL_W-1:0] sel_gray;
    logic [CFG_W-1:0] cfg_next;
    logic             in_wait;
    logic             want_high;
    logic             poll_match;
    logic             poll_hit;
    logic             poll_expire;

    dllph_gray_enc #(.W(SEL_W)) gray_i (
        .bin_i  (s_q.phase),
        .gray_o (sel_gray)
    );

    assign in_wait    = (s_q.state == ST_WAIT_LOW) || (s_q.state == ST_WAIT_HIGH);
    assign want_high  = (s_q.state == ST_WAIT_HIGH);
    assign poll_match = want_high ? cko_status_i : !cko_status_i;

    dllph_poll_timer #(
        .CYCLES_PER_US (CYCLES_PER_US),
        .MAX_POLLS     (MAX_POLLS)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (in_wait),
        .match_i  (poll_match),
        .hit_o    (poll_hit),
        .expire_o (poll_expire)
    );

    dllph_cfg_update upd_i (
        .cfg_i (s_q.cfg),
        .op_i  (op),
        .sel_i (sel_gray),
        .cfg_o (cfg_next)
    );

    always_comb begin
        op     = OP_HOLD;
        s_d    = s_q;
        s_d.done = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.phase   = phase_i;
                    s_d.timeout = 1'b0;
                    s_d.state   = ST_PREP;
                end
            end
            ST_PREP: begin
                op        = OP_PREP;
                s_d.state = ST_WAIT_LOW;
            end
            ST_WAIT_LOW: begin
                if (poll_hit) begin
                    s_d.state = ST_LOAD_SEL;
                end else if (poll_expire) begin
                    s_d.timeout = 1'b1;
                    s_d.state   = ST_IDLE;
                end
            end
            ST_LOAD_SEL: begin
                op        = OP_LOAD;
                s_d.state = ST_RAISE_CKO;
            end
            ST_RAISE_CKO: begin
                op        = OP_RAISE;
                s_d.state = ST_WAIT_HIGH;
            end
            ST_WAIT_HIGH: begin
                if (poll_hit) begin
                    s_d.state = ST_HANDOVER;
                end else if (poll_expire) begin
                    s_d.timeout = 1'b1;
                    s_d.state   = ST_IDLE;
                end
            end
            ST_HANDOVER: begin
                op        = OP_HAND;
                s_d.done  = 1'b1;
                s_d.state = ST_IDLE;
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
        s_d.cfg = cfg_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, phase: '0, cfg: '0, done: 1'b0, timeout: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_word_o = s_q.cfg;
    assign busy_o     = (s_q.state != ST_IDLE);
    assign done_o     = s_q.done;
    assign timeout_o  = s_q.timeout;

    AST_SEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_word_o[SEL_LSB +: SEL_W]) |-> !cfg_word_o[B_CKO] && !$past(cfg_word_o[B_CKO])); // R3
    AST_SEL_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_word_o[SEL_LSB +: SEL_W]) |-> !$past(cko_status_i, 2)); // R3
    AST_CKO_RISE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_word_o[B_CKO]) |-> cfg_word_o[B_DLL] && cfg_word_o[B_EXT] && !cfg_word_o[B_RCV]); // R4
    AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_word_o[B_RCV]) |-> $fell(cfg_word_o[B_EXT]) && cfg_word_o[B_CKO] && $past(cko_status_i, 2)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R5
    AST_DONE_NOT_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o)); // R7
    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o && !busy_o && !start_i |=> timeout_o); // R7
    AST_TIMEOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !timeout_o); // R8
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(s_q.phase)); // R9
    AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word_o & ~CFG_MASK) == '0); // R10

endmodule

// File: tb/dllph_programmer_tb_top.sv
module dllph_programmer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 5;
    localparam int MAXP       = 50;
    localparam logic [3:0] GTAB [16] = '{4'h0, 4'h1, 4'h3, 4'h2, 4'h6, 4'h7, 4'h5, 4'h4,
                                         4'hC, 4'hD, 4'hF, 4'hE, 4'hA, 4'hB, 4'h9, 4'h8};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  phase = '0;
    logic        status;
    logic [31:0] cfg;
    logic        busy, done, tmo;

    logic [255:0] hist;
    int           lat = 0;
    int           smode = 0;

    int  vectors = 0;
    int  miscompares = 0;
    bit  prev_ck = 1'b0;
    logic [3:0] prev_sel = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dllph_programmer #(.CYCLES_PER_US(CPU), .MAX_POLLS(MAXP)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .phase_i      (phase),
        .cko_status_i (status),
        .cfg_word_o   (cfg),
        .busy_o       (busy),
        .done_o       (done),
        .timeout_o    (tmo)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[254:0], cfg[18]};
    end

    always_comb begin
        if (smode == 1)      status = 1'b1;
        else if (smode == 2) status = 1'b0;
        else if (lat == 0)   status = cfg[18];
        else                 status = hist[lat-1];
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    task automatic run_seq(input logic [3:0] p, input int l, input int mode, input bit inject);
        int k1, k2, exp_n, n, outcome;
        logic [31:0] exp_cfg;
        bit saw_done;
        lat = l;
        smode = mode;
        if (mode == 1) begin
            k1 = MAXP; k2 = 0;
        end else if (mode == 2) begin
            k1 = 0; k2 = MAXP;
        end else begin
            k1 = prev_ck ? cdiv(l, CPU) : 0;
            k2 = cdiv(l, CPU);
        end
        if (k1 > MAXP - 1) begin
            outcome = 1; exp_n = 3 + (MAXP - 1) * CPU;
            exp_cfg = {8'h00, prev_sel, 4'h9, 16'h0000};
        end else if (k2 > MAXP - 1) begin
            outcome = 2; exp_n = 6 + k1 * CPU + (MAXP - 1) * CPU;
            exp_cfg = {8'h00, GTAB[p], 4'hD, 16'h0000};
        end else begin
            outcome = 0; exp_n = 7 + (k1 + k2) * CPU;
            exp_cfg = {8'h00, GTAB[p], 4'h7, 16'h0000};
        end
        @(negedge clk);
        start = 1'b1;
        phase = p;
        n = 0;
        saw_done = 1'b0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) begin
                start = 1'b0;
                check(busy == 1'b1, "R9 busy after accept", longint'(busy), 1);
                check(tmo == 1'b0, "R8 timeout cleared on start", longint'(tmo), 0);
            end
            if (inject && n == 3) begin
                start = 1'b1;
                phase = ~p;
            end
            if (inject && n == 4) start = 1'b0;
            if (done) saw_done = 1'b1;
            if (done || tmo || n > 4000) break;
        end
        check(n == exp_n, "R6 cycles to finish", longint'(n), longint'(exp_n));
        check(cfg == exp_cfg, outcome == 0 ? "R2 final cfg word" : "R7 cfg at abort",
              longint'(cfg), longint'(exp_cfg));
        check(saw_done == (outcome == 0), "R5 done vs outcome", longint'(saw_done), longint'(outcome == 0));
        check(tmo == (outcome != 0), "R7 timeout flag", longint'(tmo), longint'(outcome != 0));
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", longint'(done), 0);
        check(busy == 1'b0, "R9 idle after run", longint'(busy), 0);
        repeat (300) @(negedge clk);
        check(tmo == (outcome != 0), "R7 timeout sticky", longint'(tmo), longint'(outcome != 0));
        check((cfg & 32'hFF00_FFFF) == 32'h0, "R10 outside bits zero", longint'(cfg), 0);
        prev_ck = (outcome != 1);
        if (outcome != 1) prev_sel = GTAB[p];
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        miscompares++;
        vectors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(cfg == 32'h0, "R1 cfg after reset", longint'(cfg), 0);
        check(!busy && !done && !tmo, "R1 flags after reset", longint'({busy, done, tmo}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cfg == 32'h0, "R1 cfg idle", longint'(cfg), 0);

        run_seq(4'd0, 0, 0, 1'b0);
        run_seq(4'd15, 7, 0, 1'b0);
        run_seq(4'd5, 20, 0, 1'b1);     // R9 start while busy ignored
        run_seq(4'd9, 0, 1, 1'b0);      // R7 stuck high in low wait
        run_seq(4'd3, 3, 0, 1'b0);      // R8 clears previous timeout
        run_seq(4'd6, 245, 0, 1'b0);    // R6 last allowed poll
        run_seq(4'd12, 246, 0, 1'b0);   // R7 one poll too many
        run_seq(4'd10, 0, 2, 1'b0);     // R7 stuck low in high wait
        for (int i = 0; i < 16; i++) begin
            run_seq(4'(i), 1, 0, 1'b0); // R2 every gray code
        end
        for (int i = 0; i < 40; i++) begin
            int r;
            int m;
            r = int'($urandom % 100);
            m = (r < 8) ? 1 : (r < 16) ? 2 : 0;
            run_seq(4'($urandom % 16), int'($urandom % 64), m, ($urandom % 4) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule